// File: doc/BRIEF.md
# Shift and Rotate Flag Unit

This unit evaluates one shift or rotate operation per cycle on an 8-, 16- or 32-bit operand. It produces the new operand value and the new carry and overflow flags. It also raises two qualifiers: one tells whether the destination is to be rewritten, the other whether the flags are to be updated. The supported operations are shift-left, rotate-left, rotate-right, and rotate-left and rotate-right through the carry flag.

An execution pipeline presents the operation, operand size, operand, raw count and the current carry together with a valid strobe. One cycle later it consumes the registered result. Most of the logic is count handling, and it follows the exact rules for each width. The raw count is first cut to its low five bits. Plain rotates on narrow operands then reduce it modulo the width. Rotates through carry reduce it modulo the width plus one. There is one corner where a narrow plain rotate updates the flags while leaving the operand untouched.

Top module: `sr_flag_unit`

## Requirements
- R1: While reset is asserted, and after it until the first valid input, `out_vld`, `out_wr`, `out_flg_upd` and `out_res` are all zero.
- R2: Outputs appear exactly one cycle after `in_vld`. `out_vld` mirrors `in_vld` delayed by one cycle, and every other output holds its value in cycles where `in_vld` was low.
- R3: Operation code 0 is shift-left, and only count bits 4..0 are used. When those five bits are zero, the unit writes nothing and updates no flags. In that case the result is the operand, the carry equals `in_cf`, and overflow is 0. Count bits above bit 4 never matter for any operation.
- R4: For shift-left with a 5-bit count c where 1 <= c <= width, the result is the operand shifted left by c. The carry is operand bit width-c, and overflow is that carry XOR the result's top bit. Both enables are set.
- R5: For an 8- or 16-bit shift-left with c greater than the width, the result, carry and overflow are all 0, and both enables are set.
- R6: Operation code 1 is rotate-left by c mod width. The carry becomes result bit 0, and overflow becomes bit 0 XOR the top bit.
- R7: Operation code 2 is rotate-right by c mod width. The carry becomes the result's top bit, and overflow becomes the top bit XOR the bit below it.
- R8: For an 8- or 16-bit plain rotate, c can be nonzero while c mod width is zero. In that case the operand is not rewritten (`out_wr`=0) but the flags are updated (`out_flg_upd`=1). The carry and overflow come from the unchanged operand by the rules of R6 and R7.
- R9: A plain rotate with c = 0 changes nothing, at any width.
- R10: Operation code 3 is rotate-left through carry by c mod 9 (8-bit), c mod 17 (16-bit) or c (32-bit). The incoming carry enters at bit position count-1. The new carry is operand bit width-count, and overflow is the new carry XOR the result's top bit. A reduced count of zero changes nothing.
- R11: Operation code 4 is rotate-right through carry with the same count reduction as R10. The incoming carry enters at bit position width-count. The new carry is operand bit count-1, and overflow is the XOR of the result's two top bits. A reduced count of zero changes nothing.
- R12: Operation codes 5..7 and size code 3 have no effect. Both enables are 0, the carry equals `in_cf`, and overflow is 0. The result is the operand truncated to the width, or all 32 input bits when the size code is 3.
- R13: Size codes 0, 1 and 2 select 8, 16 and 32 bits. For 8- and 16-bit operations, result bits above the width are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input operation valid |
| in_op | input | 3 | Operation code (0 shl, 1 rol, 2 ror, 3 rcl, 4 rcr) |
| in_size | input | 2 | Operand size code (0: 8, 1: 16, 2: 32 bits) |
| in_val | input | 32 | Operand value |
| in_cnt | input | 8 | Raw count; only bits 4..0 are used |
| in_cf | input | 1 | Incoming carry flag |
| out_vld | output | 1 | Registered outputs valid |
| out_res | output | 32 | Result, zero-extended above the operand width |
| out_wr | output | 1 | Destination rewrite enable |
| out_cf | output | 1 | New carry flag |
| out_of | output | 1 | New overflow flag |
| out_flg_upd | output | 1 | Flags update enable |

## Verification
There is one cycle where the two enables split. Flag update and destination rewrite normally rise together. For a narrow plain rotate whose count is a nonzero multiple of the width, however, the flag update must rise while the rewrite stays low. The bench sweeps every operation, every size code and every 5-bit count, once with the high count bits clear and once with them set, over several operand patterns and both carry values. The sweep therefore lands on the multiples 8, 16 and 24 for bytes and on 16 for halfwords. Each of those cycles is judged against a bit-at-a-time reference model, which computes the expected enables, carry and overflow separately.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int SR_BASE_W    = 8;
  localparam int SR_NUM_SIZES = 3;
  localparam int SR_DATA_W    = SR_BASE_W << (SR_NUM_SIZES - 1);
  localparam int SR_SZ_W      = 2;
  localparam int SR_OP_W      = 3;
  localparam int SR_CNT5_W    = 5;

  typedef enum logic [SR_OP_W-1:0] {
    OP_SHL = 3'd0,
    OP_ROL = 3'd1,
    OP_ROR = 3'd2,
    OP_RCL = 3'd3,
    OP_RCR = 3'd4
  } sr_op_e;

  typedef struct packed {
    logic [SR_DATA_W-1:0] res;
    logic                 wr;
    logic                 upd;
    logic                 cf;
    logic                 of;
  } sr_res_t;
endpackage

// File: rtl/sr_lane.sv
// One width lane: all five operations for a W-bit operand.
module sr_lane
  import sr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [SR_OP_W-1:0]   op,
  input  logic [W-1:0]         val,
  input  logic [SR_CNT5_W-1:0] cnt5,
  input  logic                 cfi,
  output logic [W-1:0]         res,
  output logic                 wr,
  output logic                 upd,
  output logic                 cf,
  output logic                 of
);
  localparam int EW = W + 1;
  localparam int CW = 6;

  logic [CW-1:0]     rot_c;
  logic [CW-1:0]     thr_c;
  logic              shl_big;
  logic [W:0]        shl_w;
  logic [2*W-1:0]    dbl;
  logic [W-1:0]      rol_v;
  logic [W-1:0]      ror_v;
  logic [EW-1:0]     ext;
  logic [2*EW-1:0]   edbl;
  logic [EW-1:0]     rcl_e;
  logic [EW-1:0]     rcr_e;

  // Count reductions: plain rotates wrap at W, through-carry rotates at W+1.
  assign rot_c   = CW'(cnt5 % W);
  assign thr_c   = CW'(cnt5 % EW);
  assign shl_big = CW'(cnt5) > CW'(W);

  // Shift-left keeps one extra bit to catch the last bit shifted out.
  assign shl_w = EW'({1'b0, val} << cnt5);

  // Rotates as windows into doubled copies of the operand.
  assign dbl   = {val, val};
  assign rol_v = W'((dbl << rot_c) >> W);
  assign ror_v = W'(dbl >> rot_c);

  assign ext   = {cfi, val};
  assign edbl  = {ext, ext};
  assign rcl_e = EW'((edbl << thr_c) >> EW);
  assign rcr_e = EW'(edbl >> thr_c);

  always_comb begin
    res = val;
    wr  = 1'b0;
    upd = 1'b0;
    cf  = cfi;
    of  = 1'b0;
    unique case (op)
      OP_SHL: begin
        if (cnt5 != '0) begin
          wr  = 1'b1;
          upd = 1'b1;
          if (shl_big) begin
            res = '0;
            cf  = 1'b0;
            of  = 1'b0;
          end else begin
            res = shl_w[W-1:0];
            cf  = shl_w[W];
            of  = shl_w[W] ^ shl_w[W-1];
          end
        end
      end
      OP_ROL: begin
        if (cnt5 != '0) begin
          upd = 1'b1;
          wr  = (rot_c != '0);
          res = rol_v;
          cf  = rol_v[0];
          of  = rol_v[0] ^ rol_v[W-1];
        end
      end
      OP_ROR: begin
        if (cnt5 != '0) begin
          upd = 1'b1;
          wr  = (rot_c != '0);
          res = ror_v;
          cf  = ror_v[W-1];
          of  = ror_v[W-1] ^ ror_v[W-2];
        end
      end
      OP_RCL: begin
        if (thr_c != '0) begin
          wr  = 1'b1;
          upd = 1'b1;
          res = rcl_e[W-1:0];
          cf  = rcl_e[W];
          of  = rcl_e[W] ^ rcl_e[W-1];
        end
      end
      OP_RCR: begin
        if (thr_c != '0) begin
          wr  = 1'b1;
          upd = 1'b1;
          res = rcr_e[W-1:0];
          cf  = rcr_e[W];
          of  = rcr_e[W-1] ^ rcr_e[W-2];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sr_select.sv
// Picks the lane addressed by the size code, or the no-effect bypass.
module sr_select
  import sr_pkg::*;
#(
  parameter int NUM = SR_NUM_SIZES
) (
  input  sr_res_t [NUM-1:0]     lanes,
  input  logic [SR_SZ_W-1:0]    size,
  input  sr_res_t               bypass,
  output sr_res_t               sel
);
  always_comb begin
    sel = bypass;
    for (int i = 0; i < NUM; i++) begin
      if (size == SR_SZ_W'(i)) sel = lanes[i];
    end
  end
endmodule

// File: rtl/sr_flag_unit.sv
module sr_flag_unit
  import sr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [SR_OP_W-1:0]   in_op,
  input  logic [SR_SZ_W-1:0]   in_size,
  input  logic [SR_DATA_W-1:0] in_val,
  input  logic [CNT_W-1:0]     in_cnt,
  input  logic                 in_cf,
  output logic                 out_vld,
  output logic [SR_DATA_W-1:0] out_res,
  output logic                 out_wr,
  output logic                 out_cf,
  output logic                 out_of,
  output logic                 out_flg_upd
);
  logic [SR_CNT5_W-1:0]        cnt5;
  logic                        unused_cnt_hi;
  sr_res_t [SR_NUM_SIZES-1:0]  lanes;
  sr_res_t                     bypass;
  sr_res_t                     sel;
  sr_res_t                     q_d, q_r;
  logic                        vld_d, vld_r;

  assign cnt5          = in_cnt[SR_CNT5_W-1:0];
  assign unused_cnt_hi = ^in_cnt[CNT_W-1:SR_CNT5_W];

  for (genvar g = 0; g < SR_NUM_SIZES; g++) begin : g_lane
    localparam int LW = SR_BASE_W << g;
    logic [LW-1:0] l_res;
    logic          l_wr, l_upd, l_cf, l_of;
    sr_res_t       l_pack;

    sr_lane #(.W(LW)) u_lane (
      .op   (in_op),
      .val  (in_val[LW-1:0]),
      .cnt5 (cnt5),
      .cfi  (in_cf),
      .res  (l_res),
      .wr   (l_wr),
      .upd  (l_upd),
      .cf   (l_cf),
      .of   (l_of)
    );

    assign l_pack = '{res: SR_DATA_W'(l_res), wr: l_wr, upd: l_upd, cf: l_cf, of: l_of};
    assign lanes[g] = l_pack;
  end

  assign bypass = '{res: in_val, wr: 1'b0, upd: 1'b0, cf: in_cf, of: 1'b0};

  sr_select #(.NUM(SR_NUM_SIZES)) u_sel (
    .lanes  (lanes),
    .size   (in_size),
    .bypass (bypass),
    .sel    (sel)
  );

  // Next state: load on valid, hold otherwise.
  always_comb begin
    vld_d = in_vld;
    q_d   = in_vld ? sel : q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_r <= 1'b0;
      q_r   <= '0;
    end else begin
      vld_r <= vld_d;
      q_r   <= q_d;
    end
  end

  assign out_vld     = vld_r;
  assign out_res     = q_r.res;
  assign out_wr      = q_r.wr;
  assign out_cf      = q_r.cf;
  assign out_of      = q_r.of;
  assign out_flg_upd = q_r.upd;
endmodule

// File: rtl/sr_flag_unit_chk.sv
module sr_flag_unit_chk
  import sr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_vld,
  input logic [SR_OP_W-1:0]   in_op,
  input logic [SR_SZ_W-1:0]   in_size,
  input logic [SR_DATA_W-1:0] in_val,
  input logic [CNT_W-1:0]     in_cnt,
  input logic                 in_cf,
  input logic                 out_vld,
  input logic [SR_DATA_W-1:0] out_res,
  input logic                 out_wr,
  input logic                 out_cf,
  input logic                 out_of,
  input logic                 out_flg_upd
);
  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  // R2
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(out_res) && $stable(out_wr) && $stable(out_flg_upd)
                 && $stable(out_cf) && $stable(out_of)));
  // R3
  shl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op == 3'd0 && in_cnt[4:0] == 5'd0) |=> (!out_wr && !out_flg_upd && !out_of));
  // R8
  rot_flag_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (in_op == 3'd1 || in_op == 3'd2) && in_size == 2'd0
     && in_cnt[2:0] == 3'd0 && in_cnt[4:3] != 2'd0) |=> (out_flg_upd && !out_wr));
  // R12
  no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (in_op > 3'd4 || in_size == 2'd3)) |=> (!out_wr && !out_flg_upd && !out_of));
  // R13
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_size == 2'd0) |=> (out_res[SR_DATA_W-1:8] == '0));
  // R4
  wr_implies_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> out_flg_upd);
endmodule

bind sr_flag_unit sr_flag_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op), .in_size(in_size),
  .in_val(in_val), .in_cnt(in_cnt), .in_cf(in_cf), .out_vld(out_vld),
  .out_res(out_res), .out_wr(out_wr), .out_cf(out_cf), .out_of(out_of),
  .out_flg_upd(out_flg_upd)
);

// File: tb/tb_sr_flag_unit.sv
module tb_sr_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [2:0]  in_op;
  logic [1:0]  in_size;
  logic [31:0] in_val;
  logic [7:0]  in_cnt;
  logic        in_cf;
  logic        out_vld;
  logic [31:0] out_res;
  logic        out_wr, out_cf, out_of, out_flg_upd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sr_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op), .in_size(in_size),
    .in_val(in_val), .in_cnt(in_cnt), .in_cf(in_cf), .out_vld(out_vld),
    .out_res(out_res), .out_wr(out_wr), .out_cf(out_cf), .out_of(out_of),
    .out_flg_upd(out_flg_upd)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  // Bit-at-a-time reference built from the requirements.
  task automatic ref_model(input int op, input int sz, input logic [31:0] v,
                           input logic [7:0] cnt, input logic ci,
                           output logic [31:0] r, output logic wr, output logic upd,
                           output logic cf, output logic of, output string tag);
    int w, c5, rc;
    logic [31:0] m, x;
    logic cc, nc;
    w  = 8 << (sz > 2 ? 2 : sz);
    m  = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    x  = v & m;
    c5 = int'(cnt[4:0]);
    r = x; wr = 1'b0; upd = 1'b0; cf = ci; of = 1'b0;
    if (sz == 3 || op > 4) begin
      tag = "R12";
      if (sz == 3) r = v;
      return;
    end
    case (op)
      0: begin
        if (c5 == 0) tag = "R3";
        else if (c5 > w) begin
          tag = "R5"; r = 32'h0; wr = 1'b1; upd = 1'b1; cf = 1'b0; of = 1'b0;
        end else begin
          tag = "R4"; wr = 1'b1; upd = 1'b1;
          r  = (x << c5) & m;
          cf = x[w - c5];
          of = cf ^ r[w-1];
        end
      end
      1, 2: begin
        rc = c5 % w;
        if (c5 == 0) tag = "R9";
        else begin
          tag = (rc == 0) ? "R8" : ((op == 1) ? "R6" : "R7");
          upd = 1'b1;
          wr  = (rc != 0);
          for (int i = 0; i < rc; i++) begin
            if (op == 1) r = ((r << 1) | (r >> (w - 1))) & m;
            else         r = ((r >> 1) | ((r & 32'h1) << (w - 1))) & m;
          end
          if (op == 1) begin cf = r[0];   of = r[0] ^ r[w-1];   end
          else         begin cf = r[w-1]; of = r[w-1] ^ r[w-2]; end
        end
      end
      default: begin
        tag = (op == 3) ? "R10" : "R11";
        rc  = c5 % (w + 1);
        if (rc != 0) begin
          wr = 1'b1; upd = 1'b1; cc = ci;
          for (int i = 0; i < rc; i++) begin
            if (op == 3) begin
              nc = r[w-1];
              r  = ((r << 1) | {31'h0, cc}) & m;
            end else begin
              nc = r[0];
              r  = (r >> 1) | ({31'h0, cc} << (w - 1));
            end
            cc = nc;
          end
          cf = cc;
          if (op == 3) of = cc ^ r[w-1];
          else         of = r[w-1] ^ r[w-2];
        end
      end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete (got hang, expected finish)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [3];
    logic [31:0] er, hold_res;
    logic ewr, eupd, ecf, eof, hold_wr;
    string tag;
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h5A3C_96E1;
    pats[2] = 32'hC3F0_7F40;

    rst_n = 1'b0; in_vld = 1'b0; in_op = '0; in_size = '0;
    in_val = '0; in_cnt = '0; in_cf = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_vld == 1'b0 && out_wr == 1'b0 && out_flg_upd == 1'b0 && out_res == 32'h0, "R1",
          $sformatf("reset: got vld=%b wr=%b upd=%b res=%h expected 0 0 0 0",
                    out_vld, out_wr, out_flg_upd, out_res));
    rst_n = 1'b1;
    @(negedge clk);
    check(out_vld == 1'b0 && out_res == 32'h0, "R1",
          $sformatf("after reset idle: got vld=%b res=%h expected 0 0", out_vld, out_res));

    for (int op = 0; op < 8; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int c = 0; c < 64; c++) begin
          for (int p = 0; p < 3; p++) begin
            for (int ci = 0; ci < 2; ci++) begin
              in_vld  = 1'b1;
              in_op   = 3'(op);
              in_size = 2'(sz);
              in_val  = pats[p];
              // upper count bits set on the second half: R3 masking
              in_cnt  = (c < 32) ? 8'(c) : (8'(c & 31) | 8'hE0);
              in_cf   = ci[0];
              ref_model(op, sz, pats[p], in_cnt, ci[0], er, ewr, eupd, ecf, eof, tag);
              @(negedge clk);
              check(out_vld && out_res == er && out_wr == ewr && out_flg_upd == eupd &&
                    out_cf == ecf && out_of == eof, tag,
                    $sformatf("op=%0d sz=%0d cnt=%h val=%h cf=%0d: got vld=%b res=%h wr=%b upd=%b cf=%b of=%b expected vld=1 res=%h wr=%b upd=%b cf=%b of=%b",
                              op, sz, in_cnt, pats[p], ci, out_vld, out_res, out_wr,
                              out_flg_upd, out_cf, out_of, er, ewr, eupd, ecf, eof));
              if (sz < 2 && op < 5) begin
                // R13: bits above the width are zero
                check(((out_res >> (8 << sz)) == 32'h0), "R13",
                      $sformatf("upper bits sz=%0d: got res=%h expected upper zero",
                                sz, out_res));
              end
            end
          end
        end
      end
    end

    // R2: outputs hold when no valid input
    hold_res = out_res;
    hold_wr  = out_wr;
    in_vld   = 1'b0;
    in_val   = ~in_val;
    in_op    = 3'd0;
    in_cnt   = 8'd3;
    @(negedge clk);
    check(out_vld == 1'b0 && out_res == hold_res && out_wr == hold_wr, "R2",
          $sformatf("hold: got vld=%b res=%h wr=%b expected vld=0 res=%h wr=%b",
                    out_vld, out_res, out_wr, hold_res, hold_wr));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule